// File: doc/BRIEF.md
# Capture/Compare Channel with Multi-Length PWM

This block is a single channel that sits beside a shared free-running counter. It never counts on its own. Each cycle it receives the counter value and a strobe that marks a fresh count. An 8-bit mode register sets what the channel does. It can latch the counter when an external pin changes. It can flag when the counter reaches a programmed value. It can toggle its output pin on a match. It can produce a square wave whose half-period comes from a programmable step. It can also generate a pulse-width modulated output with a period of 2^8, 2^9, 2^10, 2^11 or 2^16 counts.

Software reaches the channel through a small register port. The port has four word addresses: mode, value, configuration and flags. Event and overflow flags stay set until a write of 0 clears them. An interrupt request is raised from either flag, each under its own enable. In the variable-length PWM modes, duty updates are staged in a reload register. The reload register is copied into the active compare register at the start of each period, so a period never mixes two duty values.

Top module: `cap_cmp_channel`

## Requirements
- R1: In capture mode, a qualifying edge on `pin_in` copies `cnt_val` into the value register and sets the event flag. The pin passes through a two-stage synchroniser, so the copy is taken on the third rising clock edge after the pin changes.
- R2: Mode bits 5 and 4 select the capture edge. `10` captures only rising edges, `01` only falling edges and `11` both.
- R3: `irq` is high when the event flag is set and mode bit 0 (interrupt enable) is 1. It is also high when the overflow flag is set and config bit 2 (overflow interrupt enable) is 1. With both enables at 0, `irq` stays low even while the flags are set.
- R4: Flags live at address 3, with bit 0 = event and bit 1 = overflow. Hardware never clears them. A write of 0 to a bit clears that flag, and a write of 1 leaves it unchanged.
- R5: Mode bit layout, MSB first: 16-bit PWM, comparator enable, capture rising, capture falling, match enable, toggle enable, PWM enable, interrupt enable. Timer mode is bits 6 and 3 set (0x48). In timer mode, a strobed counter equal to the 16-bit value sets the event flag. With the strobe low, no match is seen.
- R6: Toggle mode is 0x4C. A strobed 16-bit match inverts `pin_out` and sets the event flag.
- R7: Frequency mode is 0x46. When the low byte of the strobed counter equals the low byte of the value register, `pin_out` inverts and the high byte of the value register is added to the low byte (mod 256).
- R8: With mode bit 6 at 0, the timer, toggle and frequency modes neither match nor toggle. Both PWM modes drive `pin_out` low.
- R9: Variable PWM is 0x42, with config bits 1:0 = code k selecting a period of 2^(8+k) counts. When the counter starts a period at 0, `pin_out` is high for exactly d counts, where d is the loaded duty.
- R10: At each strobed period wrap, the reload register is copied into the compare register. A duty written during a period shows only in the next period. Writes to address 1 go to the reload register when the mode is variable PWM and either k = 0 or config bit 3 is 1. Otherwise they go to the compare register, and reads follow the same steering.
- R11: In variable PWM, each strobed period wrap sets the overflow flag.
- R12: 16-bit PWM is 0xC2, with writes going straight to the compare value v. The output rises when the strobed counter is 0 (if v is not 0) and falls when it equals v.
- R13: In either PWM mode with mode bit 3 set, a strobed compare match sets the event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_tick | input | 1 | Counter holds a fresh count this cycle |
| pin_in | input | 1 | External capture pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 mode, 1 value, 2 config, 3 flags |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read address, same map |
| rd_data | output | 16 | Read data |
| pin_out | output | 1 | Channel output pin |
| evt_flag | output | 1 | Sticky event flag |
| ovf_flag | output | 1 | Sticky PWM overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the reload boundary in variable PWM. A duty write must land strictly inside a running period, and the bench must then show that the period in progress still uses the old duty while the next one uses the new value. The bench produces this by driving the counter itself, cycle by cycle. It issues the reload write in the same cycle as a mid-period count, then totals the high cycles over two whole periods. The edge-select sweep leans on the same control of the counter: the counter is held at a distinct value per edge, so the result shows both whether a capture happened and which value was latched.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

    localparam int MB_PWM16 = 7;
    localparam int MB_CMPEN = 6;
    localparam int MB_CAPR  = 5;
    localparam int MB_CAPF  = 4;
    localparam int MB_MATCH = 3;
    localparam int MB_TOG   = 2;
    localparam int MB_PWM   = 1;
    localparam int MB_IEN   = 0;

    localparam logic [1:0] SEL_MODE  = 2'd0;
    localparam logic [1:0] SEL_VALUE = 2'd1;
    localparam logic [1:0] SEL_CFG   = 2'd2;
    localparam logic [1:0] SEL_FLAG  = 2'd3;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CAPTURE,
        OP_TIMER,
        OP_TOGGLE,
        OP_FREQ,
        OP_PWMN,
        OP_PWM16
    } op_e;

    function automatic op_e decode_op(input logic [7:0] m);
        op_e r;
        if (m[MB_PWM]) begin
            if (m[MB_TOG])        r = OP_FREQ;
            else if (m[MB_PWM16]) r = OP_PWM16;
            else                  r = OP_PWMN;
        end else if (m[MB_TOG]) begin
            r = OP_TOGGLE;
        end else if (m[MB_MATCH]) begin
            r = OP_TIMER;
        end else if (m[MB_CAPR] || m[MB_CAPF]) begin
            r = OP_CAPTURE;
        end else begin
            r = OP_IDLE;
        end
        return r;
    endfunction

endpackage

// File: rtl/ccx_pin_edge.sv
module ccx_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_raw};
        last_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;

    // R1: a detected edge always reflects a change of the settled sample
    p_edge_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> (last_q != $past(last_q)));

endmodule

// File: rtl/ccx_match.sv
module ccx_match #(
    parameter int CW        = 16,
    parameter int BASE_BITS = 8,
    parameter int N_LEN     = 4
) (
    input  logic [CW-1:0] cnt_val,
    input  logic [CW-1:0] cmp_val,
    input  logic [1:0]    len_code,
    output logic [CW-1:0] len_mask,
    output logic          hit_full,
    output logic          hit_half,
    output logic          hit_len,
    output logic          wrap_len,
    output logic          wrap_full
);
    localparam int HALF = CW / 2;

    logic [CW-1:0] mask_tab [N_LEN];

    for (genvar g = 0; g < N_LEN; g++) begin : g_mask
        assign mask_tab[g] = (CW'(1) << (BASE_BITS + g)) - CW'(1);
    end

    assign len_mask  = mask_tab[len_code];
    assign hit_full  = (cnt_val == cmp_val);
    assign hit_half  = (cnt_val[HALF-1:0] == cmp_val[HALF-1:0]);
    assign hit_len   = ((cnt_val & len_mask) == (cmp_val & len_mask));
    assign wrap_len  = ((cnt_val & len_mask) == '0);
    assign wrap_full = (cnt_val == '0);

endmodule

// File: rtl/cap_cmp_channel.sv
module cap_cmp_channel
    import ccx_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_tick,
    input  logic          pin_in,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_sel,
    output logic [CW-1:0] rd_data,
    output logic          pin_out,
    output logic          evt_flag,
    output logic          ovf_flag,
    output logic          irq
);
    localparam int HALF = CW / 2;

    typedef struct packed {
        logic [7:0]    mode;
        logic [CW-1:0] cmp;
        logic [CW-1:0] arl;
        logic [1:0]    clsel;
        logic          ovf_ie;
        logic          rsel;
        logic          evt;
        logic          ovf;
        logic          pin;
    } chan_t;

    chan_t st_d, st_q;

    logic          rise, fall;
    logic [CW-1:0] len_mask;
    logic          hit_full, hit_half, hit_len, wrap_len, wrap_full;
    op_e           op;
    logic          cmp_en, steer_arl, cap_hit;

    ccx_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_in),
        .rise    (rise),
        .fall    (fall)
    );

    ccx_match #(.CW(CW), .BASE_BITS(8), .N_LEN(4)) u_match (
        .cnt_val   (cnt_val),
        .cmp_val   (st_q.cmp),
        .len_code  (st_q.clsel),
        .len_mask  (len_mask),
        .hit_full  (hit_full),
        .hit_half  (hit_half),
        .hit_len   (hit_len),
        .wrap_len  (wrap_len),
        .wrap_full (wrap_full)
    );

    assign op        = decode_op(st_q.mode);
    assign cmp_en    = st_q.mode[MB_CMPEN];
    assign steer_arl = (op == OP_PWMN) && ((st_q.clsel == 2'b00) || st_q.rsel);
    assign cap_hit   = (op == OP_CAPTURE) &&
                       ((rise && st_q.mode[MB_CAPR]) || (fall && st_q.mode[MB_CAPF]));

    always_comb begin
        st_d = st_q;

        if (wr_en) begin
            case (wr_sel)
                SEL_MODE:  st_d.mode = wr_data[7:0];
                SEL_VALUE: begin
                    if (steer_arl) st_d.arl = wr_data;
                    else           st_d.cmp = wr_data;
                end
                SEL_CFG: begin
                    st_d.clsel  = wr_data[1:0];
                    st_d.ovf_ie = wr_data[2];
                    st_d.rsel   = wr_data[3];
                end
                default: begin
                    if (!wr_data[0]) st_d.evt = 1'b0;
                    if (!wr_data[1]) st_d.ovf = 1'b0;
                end
            endcase
        end

        case (op)
            OP_CAPTURE: begin
                if (cap_hit) begin
                    st_d.cmp = cnt_val;
                    st_d.evt = 1'b1;
                end
            end
            OP_TIMER: begin
                if (cmp_en && cnt_tick && hit_full) st_d.evt = 1'b1;
            end
            OP_TOGGLE: begin
                if (cmp_en && cnt_tick && hit_full) begin
                    st_d.pin = ~st_q.pin;
                    if (st_q.mode[MB_MATCH]) st_d.evt = 1'b1;
                end
            end
            OP_FREQ: begin
                if (cmp_en && cnt_tick && hit_half) begin
                    st_d.pin = ~st_q.pin;
                    st_d.cmp[HALF-1:0] = st_q.cmp[HALF-1:0] + st_q.cmp[CW-1:HALF];
                    if (st_q.mode[MB_MATCH]) st_d.evt = 1'b1;
                end
            end
            OP_PWMN: begin
                if (cnt_tick && wrap_len) st_d.ovf = 1'b1;
                if (!cmp_en) begin
                    st_d.pin = 1'b0;
                end else if (cnt_tick) begin
                    if (wrap_len) begin
                        st_d.cmp = st_q.arl;
                        st_d.pin = ((st_q.arl & len_mask) != '0);
                    end else if (hit_len) begin
                        st_d.pin = 1'b0;
                        if (st_q.mode[MB_MATCH]) st_d.evt = 1'b1;
                    end
                end
            end
            OP_PWM16: begin
                if (!cmp_en) begin
                    st_d.pin = 1'b0;
                end else if (cnt_tick) begin
                    if (wrap_full) begin
                        st_d.pin = (st_q.cmp != '0);
                    end else if (hit_full) begin
                        st_d.pin = 1'b0;
                        if (st_q.mode[MB_MATCH]) st_d.evt = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_MODE:  rd_data[7:0] = st_q.mode;
            SEL_VALUE: rd_data = steer_arl ? st_q.arl : st_q.cmp;
            SEL_CFG:   rd_data[3:0] = {st_q.rsel, st_q.ovf_ie, st_q.clsel};
            default:   rd_data[1:0] = {st_q.ovf, st_q.evt};
        endcase
    end

    assign pin_out  = st_q.pin;
    assign evt_flag = st_q.evt;
    assign ovf_flag = st_q.ovf;
    assign irq      = (st_q.evt & st_q.mode[MB_IEN]) | (st_q.ovf & st_q.ovf_ie);

    // R1: a capture latches the counter value of that cycle
    p_capture_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (st_q.cmp == $past(cnt_val)) && evt_flag);

    // R4: the event flag stays set unless a clearing write arrives
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !(wr_en && wr_sel == SEL_FLAG && !wr_data[0])) |=> evt_flag);

    // R3: a newly raised event flag requests an interrupt when enabled
    p_irq_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_flag) && st_q.mode[MB_IEN]) |-> irq);

    // R8: PWM with the comparator off forces the pin low
    p_pwm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_PWMN || op == OP_PWM16) && !cmp_en) |=> !pin_out);

    // R8: toggle-based modes hold the pin with the comparator off
    p_toggle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_TOGGLE || op == OP_FREQ) && !cmp_en) |=> $stable(pin_out));

    // R10: the active compare takes the reload value at a period wrap
    p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PWMN && cmp_en && cnt_tick && wrap_len) |=> (st_q.cmp == $past(st_q.arl)));

endmodule

// File: tb/sim_cap_cmp_channel.sv
module sim_cap_cmp_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        cnt_tick = 1'b0;
    logic        pin_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        pin_out, evt_flag, ovf_flag, irq;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] rv;

    always #5 clk = ~clk;

    cap_cmp_channel u0 (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .pin_out(pin_out),
        .evt_flag(evt_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] d);
        @(negedge clk);
        rd_sel = s;
        #1 d = rd_data;
    endtask

    task automatic cyc(input logic [15:0] c, input logic t);
        @(negedge clk);
        cnt_val = c; cnt_tick = t;
        @(posedge clk); #1;
        cnt_tick = 1'b0;
    endtask

    task automatic pwm_period(input int len, output int high);
        high = 0;
        for (int c = 0; c < len; c++) begin
            cyc(16'(c), 1'b1);
            high += int'(pin_out);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int hi, tg, exp_tg;
        logic prev;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        check("R4 reset pin", int'(pin_out), 0);
        check("R4 reset flags", int'({ovf_flag, evt_flag}), 0);
        check("R3 reset irq", int'(irq), 0);
        rd(2'd0, rv); check("R5 reset mode", int'(rv), 0);
        rd(2'd1, rv); check("R1 reset value", int'(rv), 0);

        // R1/R2 capture edge sweep
        for (int code = 1; code < 4; code++) begin
            wr(2'd0, 16'((code << 4) | 1));
            wr(2'd1, 16'hDEAD);
            wr(2'd3, 16'h0);
            @(negedge clk) pin_in = 1'b1;
            for (int k = 0; k < 5; k++) cyc(16'h1230 + 16'(code), 1'b0);
            rd(2'd1, rv);
            check("R2 rising capture value", int'(rv), (code & 2) ? 'h1230 + code : 'hDEAD);
            check("R1 rising capture flag", int'(evt_flag), (code & 2) ? 1 : 0);
            check("R3 irq follows flag", int'(irq), (code & 2) ? 1 : 0);
            wr(2'd1, 16'hDEAD);
            wr(2'd3, 16'h0);
            @(negedge clk) pin_in = 1'b0;
            for (int k = 0; k < 5; k++) cyc(16'hABC0 + 16'(code), 1'b0);
            rd(2'd1, rv);
            check("R2 falling capture value", int'(rv), (code & 1) ? 'hABC0 + code : 'hDEAD);
            check("R1 falling capture flag", int'(evt_flag), (code & 1) ? 1 : 0);
        end

        // R3/R4: irq gating and sticky flag
        check("R4 flag still set", int'(evt_flag), 1);
        wr(2'd0, 16'h0030);
        check("R3 irq masked", int'(irq), 0);
        wr(2'd3, 16'h0001);
        check("R4 write 1 ignored", int'(evt_flag), 1);
        wr(2'd3, 16'h0002);
        check("R4 write 0 clears", int'(evt_flag), 0);

        // R5 timer
        wr(2'd0, 16'h0048);
        wr(2'd1, 16'h0123);
        for (int c = 0; c < 'h123; c++) cyc(16'(c), 1'b1);
        check("R5 no early match", int'(evt_flag), 0);
        cyc(16'h0123, 1'b0);
        check("R5 match ignored without tick", int'(evt_flag), 0);
        cyc(16'h0123, 1'b1);
        check("R5 timer match", int'(evt_flag), 1);
        wr(2'd3, 16'h0);
        wr(2'd0, 16'h0008);
        cyc(16'h0123, 1'b1);
        check("R8 timer comparator off", int'(evt_flag), 0);

        // R6 toggle mode
        wr(2'd0, 16'h004C);
        wr(2'd1, 16'h0040);
        tg = 0; prev = pin_out;
        for (int c = 0; c < 256; c++) begin
            cyc(16'(c), 1'b1);
            if (pin_out != prev) tg++;
            prev = pin_out;
        end
        check("R6 toggle count", tg, 1);
        check("R6 toggle flag", int'(evt_flag), 1);
        wr(2'd0, 16'h000C);
        tg = 0; prev = pin_out;
        for (int c = 0; c < 256; c++) begin
            cyc(16'(c), 1'b1);
            if (pin_out != prev) tg++;
            prev = pin_out;
        end
        check("R8 toggle comparator off", tg, 0);

        // R7 frequency output
        wr(2'd0, 16'h0046);
        wr(2'd1, 16'h2010);
        exp_tg = 0;
        for (int c = 0; c < 256; c++) if ((c % 'h20) == 'h10) exp_tg++;
        tg = 0; prev = pin_out;
        for (int c = 0; c < 256; c++) begin
            cyc(16'(c), 1'b1);
            if (pin_out != prev) tg++;
            prev = pin_out;
        end
        check("R7 frequency toggles", tg, exp_tg);
        wr(2'd0, 16'h0006);
        tg = 0; prev = pin_out;
        for (int c = 0; c < 256; c++) begin
            cyc(16'(c), 1'b1);
            if (pin_out != prev) tg++;
            prev = pin_out;
        end
        check("R8 frequency comparator off", tg, 0);

        // R9/R11 variable PWM sweep
        for (int cs = 0; cs < 4; cs++) begin
            int len;
            len = 1 << (8 + cs);
            for (int di = 0; di < 4; di++) begin
                int d;
                d = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? len / 2 : len - 1;
                wr(2'd2, 16'(8 | cs));
                wr(2'd0, 16'h0042);
                wr(2'd1, 16'(d));
                wr(2'd3, 16'h0);
                pwm_period(len, hi);
                check("R9 pwm high count", hi, d);
                check("R11 overflow flag", int'(ovf_flag), 1);
            end
        end
        check("R3 overflow irq disabled", int'(irq), 0);
        wr(2'd2, 16'h000C);
        check("R3 overflow irq enabled", int'(irq), 1);
        wr(2'd3, 16'h0001);
        check("R4 overflow cleared", int'(ovf_flag), 0);

        wr(2'd0, 16'h0002);
        wr(2'd1, 16'h0080);
        pwm_period(256, hi);
        check("R8 pwm comparator off", hi, 0);

        // R10 reload staging
        wr(2'd2, 16'h0009);
        wr(2'd0, 16'h0042);
        wr(2'd1, 16'd100);
        hi = 0;
        for (int c = 0; c < 512; c++) begin
            @(negedge clk);
            cnt_val = 16'(c); cnt_tick = 1'b1;
            if (c == 5) begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd300; end
            @(posedge clk); #1;
            cnt_tick = 1'b0; wr_en = 1'b0;
            hi += int'(pin_out);
        end
        check("R10 old duty kept", hi, 100);
        pwm_period(512, hi);
        check("R10 new duty next period", hi, 300);
        wr(2'd2, 16'h0001);
        wr(2'd1, 16'h0077);
        rd(2'd1, rv);
        check("R10 direct write", int'(rv), 'h77);
        wr(2'd2, 16'h0009);
        rd(2'd1, rv);
        check("R10 reload untouched", int'(rv), 300);

        // R13 match flag in PWM
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h004A);
        wr(2'd1, 16'h0040);
        wr(2'd3, 16'h0);
        for (int c = 0; c < 'h40; c++) cyc(16'(c), 1'b1);
        check("R13 no match yet", int'(evt_flag), 0);
        cyc(16'h0040, 1'b1);
        check("R13 pwm match flag", int'(evt_flag), 1);

        // R12 16-bit PWM
        wr(2'd0, 16'h00C2);
        wr(2'd1, 16'd5);
        hi = 0;
        for (int c = 0; c < 10; c++) begin
            cyc(16'(c), 1'b1);
            hi += int'(pin_out);
            if (c == 0) check("R12 rise at zero", int'(pin_out), 1);
        end
        cyc(16'hFFFF, 1'b1);
        check("R12 high count", hi, 5);
        check("R12 low at top", int'(pin_out), 0);
        wr(2'd1, 16'd0);
        cyc(16'h0000, 1'b1);
        check("R12 zero duty", int'(pin_out), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule